// File: doc/BRIEF.md
# Fixed-Latency Trigger Accept Buffer

This block sits on the fast side of a trigger readout path. A new tagged word arrives on every fast clock cycle. Each word has 40 data bits and a 2-bit cable tag. The block writes every word into a circular memory without a gap, and a write pointer advances by one on each cycle. Groups of four consecutive addresses form one slow-clock crossing, and a crossing always starts at an address whose two low bits are zero.

The accept or reject decision for a crossing arrives a fixed and known number of fast cycles after its data. The block does not keep a separate read pointer. When a decision arrives, it takes the live write pointer and subtracts the latency held in a configuration input. It then clears the two low bits of the result, which gives the first address of the delayed crossing. An accept reads out the four words of that crossing in order, and each word is marked with the buffer number that came with the accept. A reject discards the crossing.

If an accept arrives while a four-word burst is still running, it waits in a one-deep holding slot. If an accept arrives while that slot is also full, it is dropped and a sticky overflow flag is raised.

Top module: `trig_accept_buf`

## Requirements
- R1: While reset is held, and after it is released, `dout_valid` and `pend_overflow` are 0.
- R2: After reset, the word presented in the n-th fast cycle is stored at address n modulo 256. An accept sampled in cycle c reads four addresses in order: s, s+1, s+2 and s+3, where s = (c − `lat_cycles`) modulo 256 with bits [1:0] forced to zero.
- R3: Each output word carries the stored 40 data bits on `dout_data` and the stored 2-bit cable tag on `dout_tag`. It also carries, on `dout_bufnum`, the buffer number that was sampled together with the accept.
- R4: An accept that finds the block idle gives its first valid word in the cycle after the next one (two clock edges after it is sampled). `dout_valid` is then high for exactly four consecutive cycles.
- R5: A reject has no effect on the outputs or on the overflow flag. An accept raised in the same cycle as a reject counts as a reject.
- R6: An accept that arrives during a burst, while the holding slot is empty, is stored in the slot. Its burst follows the current one with no idle cycle between them, and its start address comes from the cycle in which it arrived.
- R7: An accept that arrives while a burst is running and the slot is full is dropped. It raises `pend_overflow`, and the flag stays high until reset.
- R8: An accept that arrives in the last cycle of a burst, with the slot empty, starts its own burst directly after that burst. It does not raise the overflow flag.
- R9: Address arithmetic wraps modulo 256. A write pointer smaller than the latency therefore selects a crossing near the top of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (four cycles per crossing) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din_data | input | 40 | Data bits of the incoming word |
| din_tag | input | 2 | Cable tag of the incoming word |
| trig_accept | input | 1 | One-cycle accept decision pulse |
| trig_reject | input | 1 | One-cycle reject decision pulse |
| trig_bufnum | input | 2 | Buffer number sampled with the accept |
| lat_cycles | input | 8 | Decision latency in fast cycles |
| dout_valid | output | 1 | Output word valid, one cycle per word |
| dout_data | output | 40 | Data bits of the read word |
| dout_tag | output | 2 | Cable tag of the read word |
| dout_bufnum | output | 2 | Buffer number of the accept being served |
| pend_overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
The main test sweeps every latency from 4 to 40 against all four phases of the accept cycle within a crossing. This separates an off-by-one in the pointer subtraction from an error in clearing the low bits. Very large latencies and a pointer that has just wrapped test the modulo arithmetic. In every case the written words encode their own cycle number, so the bench can recompute each expected word directly. Trigger patterns cover the idle case, back-to-back accepts, an accept on the last beat of a burst, a triple accept that must overflow, and rejects given alone or together with an accept. Together these separate the holding-slot path, the direct-start path and the drop path.

// File: rtl/tab_pkg.sv
package tab_pkg;
  localparam int TAB_DATA_W = 40;
  localparam int TAB_TAG_W  = 2;
  localparam int TAB_BUF_W  = 2;
  localparam int TAB_DEPTH  = 256;
  localparam int TAB_BURST  = 4;
  localparam int TAB_RST_STAGES = 2;
endpackage

// File: rtl/tab_ring_ram.sv
module tab_ring_ram #(
  parameter int AW = 8,
  parameter int W  = 42
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/tab_burst_seq.sv
module tab_burst_seq #(
  parameter int AW    = 8,
  parameter int BUF_W = 2,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [AW-1:0]    lat_cycles,
  input  logic             take,
  input  logic [BUF_W-1:0] bufnum,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic [BUF_W-1:0] rd_bufnum,
  output logic             busy,
  output logic             slot_full,
  output logic             overflow
);
  localparam int BW = $clog2(BURST);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);

  logic             act_q, act_d;
  logic [BW-1:0]    beat_q, beat_d;
  logic [AW-1:0]    cur_base_q, cur_base_d;
  logic [BUF_W-1:0] cur_buf_q, cur_buf_d;
  logic             pend_q, pend_d;
  logic [AW-1:0]    pend_base_q, pend_base_d;
  logic [BUF_W-1:0] pend_buf_q, pend_buf_d;
  logic             ovf_q, ovf_d;

  logic [AW-1:0] lag_addr;
  logic [AW-1:0] new_base;
  logic          last_beat;
  logic          free;

  always_comb begin
    lag_addr  = wr_ptr - lat_cycles;
    new_base  = {lag_addr[AW-1:BW], {BW{1'b0}}};
    last_beat = act_q && (beat_q == LAST_BEAT);
    free      = !act_q || last_beat;
  end

  always_comb begin
    act_d       = act_q;
    beat_d      = act_q ? beat_q + 1'b1 : beat_q;
    cur_base_d  = cur_base_q;
    cur_buf_d   = cur_buf_q;
    pend_d      = pend_q;
    pend_base_d = pend_base_q;
    pend_buf_d  = pend_buf_q;
    ovf_d       = ovf_q;
    if (free) begin
      if (pend_q) begin
        act_d      = 1'b1;
        beat_d     = '0;
        cur_base_d = pend_base_q;
        cur_buf_d  = pend_buf_q;
        if (take) begin
          pend_base_d = new_base;
          pend_buf_d  = bufnum;
        end else begin
          pend_d = 1'b0;
        end
      end else if (take) begin
        act_d      = 1'b1;
        beat_d     = '0;
        cur_base_d = new_base;
        cur_buf_d  = bufnum;
      end else begin
        act_d  = 1'b0;
        beat_d = '0;
      end
    end else if (take) begin
      if (!pend_q) begin
        pend_d      = 1'b1;
        pend_base_d = new_base;
        pend_buf_d  = bufnum;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      beat_q      <= '0;
      cur_base_q  <= '0;
      cur_buf_q   <= '0;
      pend_q      <= 1'b0;
      pend_base_q <= '0;
      pend_buf_q  <= '0;
      ovf_q       <= 1'b0;
    end else begin
      act_q       <= act_d;
      beat_q      <= beat_d;
      cur_base_q  <= cur_base_d;
      cur_buf_q   <= cur_buf_d;
      pend_q      <= pend_d;
      pend_base_q <= pend_base_d;
      pend_buf_q  <= pend_buf_d;
      ovf_q       <= ovf_d;
    end
  end

  always_comb begin
    rd_en     = act_q;
    rd_addr   = cur_base_q + AW'(beat_q);
    rd_bufnum = cur_buf_q;
    busy      = act_q;
    slot_full = pend_q;
    overflow  = ovf_q;
  end
endmodule

// File: rtl/trig_accept_buf.sv
module trig_accept_buf
  import tab_pkg::*;
#(
  parameter int DATA_W     = TAB_DATA_W,
  parameter int TAG_W      = TAB_TAG_W,
  parameter int BUF_W      = TAB_BUF_W,
  parameter int DEPTH      = TAB_DEPTH,
  parameter int BURST      = TAB_BURST,
  parameter int RST_STAGES = TAB_RST_STAGES,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din_data,
  input  logic [TAG_W-1:0]  din_tag,
  input  logic              trig_accept,
  input  logic              trig_reject,
  input  logic [BUF_W-1:0]  trig_bufnum,
  input  logic [AW-1:0]     lat_cycles,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  output logic [TAG_W-1:0]  dout_tag,
  output logic [BUF_W-1:0]  dout_bufnum,
  output logic              pend_overflow
);
  localparam int W = DATA_W + TAG_W;

  // reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // write pointer: one step per fast cycle, wraps naturally
  logic [AW-1:0] wr_ptr;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_ptr <= '0;
    else             wr_ptr <= wr_ptr + 1'b1;
  end

  logic             take;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [BUF_W-1:0] rd_bufnum;
  logic             burst_busy;
  logic             slot_full;
  logic [W-1:0]     rd_word;

  assign take = trig_accept && !trig_reject;

  tab_burst_seq #(.AW(AW), .BUF_W(BUF_W), .BURST(BURST)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ptr     (wr_ptr),
    .lat_cycles (lat_cycles),
    .take       (take),
    .bufnum     (trig_bufnum),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_bufnum  (rd_bufnum),
    .busy       (burst_busy),
    .slot_full  (slot_full),
    .overflow   (pend_overflow)
  );

  tab_ring_ram #(.AW(AW), .W(W)) u_ram (
    .clk     (clk),
    .wr_en   (1'b1),
    .wr_addr (wr_ptr),
    .wr_word ({din_tag, din_data}),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  // buffer number travels one stage to line up with the memory read
  logic [BUF_W-1:0] buf_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rd_en) buf_q <= rd_bufnum;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= rd_en;
  end

  assign dout_valid  = valid_q;
  assign dout_data   = rd_word[DATA_W-1:0];
  assign dout_tag    = rd_word[W-1:DATA_W];
  assign dout_bufnum = buf_q;
endmodule

// File: rtl/tab_checker.sv
module tab_checker #(
  parameter int BUF_W = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             trig_accept,
  input logic             trig_reject,
  input logic [BUF_W-1:0] trig_bufnum,
  input logic             burst_busy,
  input logic             slot_full,
  input logic             dout_valid,
  input logic [BUF_W-1:0] dout_bufnum,
  input logic             pend_overflow
);
  // R4 R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trig_accept && !trig_reject && !burst_busy && !slot_full)
      |=> ##1 (dout_valid && dout_bufnum == $past(trig_bufnum, 2)));

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trig_reject && !burst_busy && !slot_full) |=> ##1 !dout_valid);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_overflow |=> pend_overflow);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pend_overflow) |-> $past(trig_accept && !trig_reject && slot_full));

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dout_valid |-> $past(burst_busy));
endmodule

bind trig_accept_buf tab_checker #(.BUF_W(BUF_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .trig_accept   (trig_accept),
  .trig_reject   (trig_reject),
  .trig_bufnum   (trig_bufnum),
  .burst_busy    (burst_busy),
  .slot_full     (slot_full),
  .dout_valid    (dout_valid),
  .dout_bufnum   (dout_bufnum),
  .pend_overflow (pend_overflow)
);

// File: tb/trig_accept_buf_tb.sv
module trig_accept_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] din_data;
  logic [1:0]  din_tag;
  logic        trig_accept;
  logic        trig_reject;
  logic [1:0]  trig_bufnum;
  logic [7:0]  lat_cycles;
  logic        dout_valid;
  logic [39:0] dout_data;
  logic [1:0]  dout_tag;
  logic [1:0]  dout_bufnum;
  logic        pend_overflow;

  always #2.5 clk = ~clk;

  trig_accept_buf u_dut (
    .clk(clk), .rst_n(rst_n), .din_data(din_data), .din_tag(din_tag),
    .trig_accept(trig_accept), .trig_reject(trig_reject),
    .trig_bufnum(trig_bufnum), .lat_cycles(lat_cycles),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_tag(dout_tag),
    .dout_bufnum(dout_bufnum), .pend_overflow(pend_overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [43:0] expq [$];

  function automatic logic [39:0] fdat(int n);
    return {n[7:0] ^ 8'hC3, n};
  endfunction

  function automatic logic [1:0] ftag(int n);
    return n[3:2] ^ n[9:8];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R2 R3: the words of the crossing that the latency selects
  task automatic push_acc(int c, int lat, logic [1:0] b);
    int s = c - lat;
    s = s - (s % 4);
    for (int k = 0; k < 4; k++) expq.push_back({fdat(s + k), ftag(s + k), b});
  endtask

  task automatic step(bit a, bit r, logic [1:0] b);
    logic [43:0] e;
    din_data    = fdat(cyc);
    din_tag     = ftag(cyc);
    trig_accept = a;
    trig_reject = r;
    trig_bufnum = b;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (dout_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R2 unexpected word", {dout_data, dout_tag, dout_bufnum}, 0);
      end else begin
        e = expq.pop_front();
        chk({dout_data, dout_tag, dout_bufnum} == e, "R2 R3 word",
            {dout_data, dout_tag, dout_bufnum}, e);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0);
  endtask

  task automatic expect_run(int n, string req);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 2'd0);
      chk(dout_valid, req, dout_valid, 1);
    end
    step(0, 0, 2'd0);
    chk(!dout_valid, req, dout_valid, 0);
  endtask

  task automatic single(int lat, logic [1:0] b, string req);
    lat_cycles = 8'(lat);
    push_acc(cyc, lat, b);
    step(1, 0, b);
    chk(!dout_valid, "R4 early", dout_valid, 0);
    expect_run(4, req);
  endtask

  initial begin
    rst_n = 1'b0;
    din_data = '0; din_tag = '0; trig_accept = 0; trig_reject = 0;
    trig_bufnum = '0; lat_cycles = 8'd8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dout_valid, "R1 valid in reset", dout_valid, 0);
    chk(!pend_overflow, "R1 overflow in reset", pend_overflow, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    cyc = 0;
    chk(!dout_valid, "R1 valid after reset", dout_valid, 0);
    idle(300);

    // R2 R4: latency sweep against every phase within a crossing
    for (int lat = 4; lat <= 40; lat++)
      for (int ph = 0; ph < 4; ph++) begin
        while (cyc % 4 != ph) idle(1);
        single(lat, 2'((lat + ph) % 4), "R2 R4 burst");
      end
    single(100, 2'd1, "R2 long");
    single(200, 2'd2, "R2 long");
    single(244, 2'd3, "R2 long");

    // R9: pointer just wrapped, latency reaches back past address 0
    while (cyc % 256 != 3) idle(1);
    single(9, 2'd2, "R9 wrap");
    while (cyc % 256 != 1) idle(1);
    single(30, 2'd1, "R9 wrap");

    // R5: reject alone, then reject together with accept during a burst
    step(0, 1, 2'd3);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 2'd0);
      chk(!dout_valid, "R5 reject alone", dout_valid, 0);
    end
    lat_cycles = 8'd12;
    push_acc(cyc, 12, 2'd1);
    step(1, 0, 2'd1);
    step(1, 1, 2'd2);
    chk(dout_valid, "R5 burst runs", dout_valid, 1);
    idle(3);
    chk(dout_valid, "R5 burst runs", dout_valid, 1);
    step(0, 0, 2'd0);
    chk(!dout_valid, "R5 no second burst", dout_valid, 0);
    chk(!pend_overflow, "R5 flag untouched", pend_overflow, 0);
    idle(4);

    // R6: back-to-back accepts, second held and served without a gap
    lat_cycles = 8'd17;
    push_acc(cyc, 17, 2'd1);
    step(1, 0, 2'd1);
    lat_cycles = 8'd6;
    push_acc(cyc, 6, 2'd2);
    step(1, 0, 2'd2);
    chk(dout_valid, "R6 first word", dout_valid, 1);
    expect_run(7, "R6 contiguous");
    chk(!pend_overflow, "R6 no overflow", pend_overflow, 0);
    idle(3);

    // R8: accept on the last beat starts directly
    lat_cycles = 8'd20;
    push_acc(cyc, 20, 2'd3);
    step(1, 0, 2'd3);
    idle(3);
    push_acc(cyc, 20, 2'd0);
    step(1, 0, 2'd0);
    chk(dout_valid, "R8 running", dout_valid, 1);
    expect_run(4, "R8 contiguous");
    chk(!pend_overflow, "R8 no overflow", pend_overflow, 0);
    idle(3);

    // R7: third accept in a row is dropped and flag sticks
    lat_cycles = 8'd10;
    push_acc(cyc, 10, 2'd1);
    step(1, 0, 2'd1);
    push_acc(cyc, 10, 2'd2);
    step(1, 0, 2'd2);
    chk(!pend_overflow, "R7 slot only", pend_overflow, 0);
    step(1, 0, 2'd3);
    chk(pend_overflow, "R7 overflow set", pend_overflow, 1);
    expect_run(6, "R7 dropped accept");
    idle(10);
    chk(pend_overflow, "R7 sticky", pend_overflow, 1);
    chk(expq.size() == 0, "R2 words missing", expq.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-related hang: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule